// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

The block turns a 32.768 kHz clock-enable tick into a programmable periodic event for a real-time-clock style interrupt controller. A four-bit rate selector picks a period that is a power of two of base ticks. A free-running count of base ticks advances on every tick whatever the configuration. An event is recognised on the tick that carries this count onto a multiple of the selected period, so events stay phase-aligned to the shared time base when the rate changes.

Two enables gate the event. With the interrupt enable set, each event produces a one-clock strobe that the surrounding status logic uses to set both its periodic flag and its summary interrupt flag. With the square-wave enable set, each event produces a one-clock pulse on the square-wave output instead of a 50% duty waveform. Selector and enables are sampled only on base ticks, so a change applies at the next tick and can never cut or stretch a pulse.

Top module: `periodic_irq_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, both outputs are low after that edge and the base count returns to zero, so the first event after reset with selector 3 follows the fourth tick.
- R2: Selector value 0 produces no event on either output, whatever the enables.
- R3: For a selector value c from 3 to 15, events are spaced 2^(c-1) base ticks apart.
- R4: Selector value 1 gives a spacing of 128 base ticks and value 2 a spacing of 256 base ticks.
- R5: With both enables low no output pulses, while the base count keeps advancing.
- R6: With the interrupt enable high, every event raises `flag_set`; `sq_pulse` follows only the square-wave enable.
- R7: With the square-wave enable high, every event raises `sq_pulse`; `flag_set` follows only the interrupt enable.
- R8: An event occurs on the tick that makes the base count (which counts every tick since reset) a multiple of the period, also right after a selector change.
- R9: Each output pulse lasts exactly one clock and appears in the cycle after the clock edge that sampled the tick.
- R10: Selector and enables are sampled only in cycles with `tick_32k` high; a cycle without a tick never produces a pulse.
- R11: The 15-bit base count wraps at 32768, and with selector 15 an event falls on the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-clock enable per 32.768 kHz base period |
| rate_code | input | 4 | Rate selector; 0 disables events |
| pie_en | input | 1 | Periodic interrupt enable |
| sqwe_en | input | 1 | Square-wave output enable |
| flag_set | output | 1 | One-clock strobe to set the periodic and interrupt flags |
| sq_pulse | output | 1 | One-clock square-wave pulse |

## Verification
The hardest case to reach is the wrap of the 15-bit base count with the slowest selector, since only one tick in 16384 is an event. The stimulus holds selector 15 with a tick on every clock for more than 32768 cycles, so the behavioural model has to predict the event that falls on the wrap. Selector changes and enable toggles are made in the middle of a period and on cycles without a tick, which checks that alignment follows the shared count rather than the moment of the change.

// File: rtl/pid_pkg.sv
// Shared constants and types of the periodic interrupt rate divider.
// Assumes a four-bit rate selector unless a user overrides the top parameter.
package pid_pkg;
    localparam int unsigned DEF_CODE_W = 4;
    localparam int unsigned DEF_SLOW1  = 8;   // selector 1 behaves as this
    localparam int unsigned DEF_SLOW2  = 9;   // selector 2 behaves as this

    // Pair of registered event outputs
    typedef struct packed {
        logic flag;
        logic sq;
    } pid_evt_t;
endpackage

// File: rtl/pid_rate_decode.sv
// Rate selector decode: maps the selector to an effective exponent and
// builds a mask of the base-count bits that must be zero for an event.
// Assumes the selector is stable for the cycle it is sampled in.
module pid_rate_decode #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned SLOW1  = 8,
    parameter int unsigned SLOW2  = 9,
    localparam int unsigned CNT_W = (1 << CODE_W) - 1
) (
    input  logic [CODE_W-1:0] rate_code,
    output logic              active,
    output logic [CNT_W-1:0]  align_mask
);
    logic [CODE_W-1:0] eff_code;
    logic [CODE_W-1:0] shift;

    // Remap the two lowest selectors to slower rates; 0 means off
    always_comb begin
        active   = 1'b1;
        eff_code = rate_code;
        if (rate_code == '0) begin
            active   = 1'b0;
            eff_code = '0;
        end else if (rate_code == CODE_W'(1)) begin
            eff_code = CODE_W'(SLOW1);
        end else if (rate_code == CODE_W'(2)) begin
            eff_code = CODE_W'(SLOW2);
        end
        shift = active ? (eff_code - CODE_W'(1)) : '0;
    end

    // One mask bit per base-count bit below the period exponent
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign align_mask[i] = active & (shift > CODE_W'(i));
    end
endmodule

// File: rtl/pid_base_count.sv
// Free-running count of base ticks. Advances on every tick regardless of
// enables or selector so that event phase is shared by all rates.
module pid_base_count #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    // Count base ticks, wrapping naturally at 2^CNT_W
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= count + CNT_W'(1);
    end

    // R1
    reset_clears_count_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0));

    // R10
    count_holds_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

// File: rtl/pid_event_gen.sv
// Event detector: on a tick whose next count is aligned to the period,
// registers one-clock pulses gated by the two enables.
// Assumes the mask is zero-filled above the period exponent.
module pid_event_gen
    import pid_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic [CNT_W-1:0] align_mask,
    input  logic [CNT_W-1:0] count,
    input  logic             pie_en,
    input  logic             sqwe_en,
    output pid_evt_t         evt
);
    logic [CNT_W-1:0] count_nxt;
    logic             hit;

    // Decide whether this tick lands on a period boundary
    always_comb begin
        count_nxt = count + CNT_W'(1);
        hit       = tick & active & ((count_nxt & align_mask) == '0);
    end

    // Register the gated pulses for one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt.flag <= 1'b0;
            evt.sq   <= 1'b0;
        end else begin
            evt.flag <= hit & pie_en;
            evt.sq   <= hit & sqwe_en;
        end
    end

    // R6
    flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.flag |-> $past(pie_en));

    // R7
    sq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.sq |-> $past(sqwe_en));
endmodule

// File: rtl/periodic_irq_divider.sv
// Top of the periodic interrupt rate divider. Joins the selector decode,
// the shared base counter and the event detector.
// Assumes tick_32k is a single-clock enable at most once per clock.
module periodic_irq_divider
    import pid_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W,
    parameter int unsigned SLOW1  = DEF_SLOW1,
    parameter int unsigned SLOW2  = DEF_SLOW2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    input  logic              sqwe_en,
    output logic              flag_set,
    output logic              sq_pulse
);
    localparam int unsigned CNT_W = (1 << CODE_W) - 1;

    logic             active;
    logic [CNT_W-1:0] align_mask;
    logic [CNT_W-1:0] count;
    pid_evt_t         evt;

    pid_rate_decode #(.CODE_W(CODE_W), .SLOW1(SLOW1), .SLOW2(SLOW2)) u_decode (
        .rate_code (rate_code),
        .active    (active),
        .align_mask(align_mask)
    );

    pid_base_count #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_32k),
        .count(count)
    );

    pid_event_gen #(.CNT_W(CNT_W)) u_event (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_32k),
        .active    (active),
        .align_mask(align_mask),
        .count     (count),
        .pie_en    (pie_en),
        .sqwe_en   (sqwe_en),
        .evt       (evt)
    );

    assign flag_set = evt.flag;
    assign sq_pulse = evt.sq;

    // R9
    flag_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> !flag_set);

    // R9
    sq_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_pulse |=> !sq_pulse);

    // R10
    pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set || sq_pulse) |-> $past(tick_32k));

    // R2
    no_pulse_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set || sq_pulse) |-> ($past(rate_code) != '0));
endmodule

// File: tb/periodic_irq_divider_tb_top.sv
// Bench: behavioural model of the divider compared against the outputs
// on every clock.
module periodic_irq_divider_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqwe_en = 1'b0;
    logic       flag_set;
    logic       sq_pulse;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    m_cnt = 0;
    bit    e_flag = 0;
    bit    e_sq = 0;
    int    n_flag_seen = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    periodic_irq_divider dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_32k(tick_32k),
        .rate_code(rate_code),
        .pie_en  (pie_en),
        .sqwe_en (sqwe_en),
        .flag_set(flag_set),
        .sq_pulse(sq_pulse)
    );

    function automatic int period_of(input int code);
        int e;
        e = (code == 1) ? 8 : (code == 2) ? 9 : code;
        return 1 << (e - 1);
    endfunction

    // Apply a tick value, advance the model, wait a clock, compare
    task automatic step(input bit tk);
        bit hit;
        tick_32k = tk;
        if (!rst_n) begin
            m_cnt = 0; e_flag = 0; e_sq = 0;
        end else begin
            hit = tk && (rate_code != 0) &&
                  (((m_cnt + 1) % period_of(int'(rate_code))) == 0);
            e_flag = hit && pie_en;
            e_sq   = hit && sqwe_en;
            if (tk) m_cnt = (m_cnt + 1) % 32768;
        end
        @(negedge clk);
        n_cmp++;
        if (flag_set) n_flag_seen++;
        if (flag_set !== e_flag || sq_pulse !== e_sq) begin
            n_bad++;
            $display("FAIL %s flag/sq actual=%b%b expected=%b%b at %0t",
                     cur_req, flag_set, sq_pulse, e_flag, e_sq, $time);
        end
    endtask

    task automatic run(input int cycles, input int tick_every);
        for (int i = 0; i < cycles; i++) step((i % tick_every) == tick_every - 1);
    endtask

    initial begin
        #(CLK_PERIOD * 300000);
        n_bad++;
        $display("FAIL %s watchdog actual=running expected=finished", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state with ticks and enables present
        cur_req = "R1"; rate_code = 4'd3; pie_en = 1; sqwe_en = 1;
        run(6, 1);
        rst_n = 1;
        // R1: first event after the fourth tick
        run(12, 1);
        // R3 and R6: selector 3, interrupt only, tick every clock
        cur_req = "R6"; sqwe_en = 0;
        run(40, 1);
        // R3 and R7: selector 6, square wave only, sparse ticks
        cur_req = "R7"; rate_code = 4'd6; pie_en = 0; sqwe_en = 1;
        run(400, 3);
        // R4: selectors 1 and 2, both enables
        cur_req = "R4"; rate_code = 4'd1; pie_en = 1;
        run(700, 1);
        rate_code = 4'd2;
        run(1100, 2);
        // R2: selector 0 with both enables
        cur_req = "R2"; n_flag_seen = 0; rate_code = 4'd0;
        run(600, 1);
        if (n_flag_seen != 0) begin
            n_bad++;
            $display("FAIL R2 pulses actual=%0d expected=0", n_flag_seen);
        end
        n_cmp++;
        // R5: both enables low, count advances
        cur_req = "R5"; rate_code = 4'd4; pie_en = 0; sqwe_en = 0;
        run(75, 1);
        // R8: alignment continues across the disabled stretch
        cur_req = "R8"; pie_en = 1;
        run(50, 1);
        // R8: selector change mid-period, changes on non-tick cycles
        rate_code = 4'd5; run(37, 1);
        rate_code = 4'd3; run(23, 2);
        step(0); rate_code = 4'd7; step(0);
        // R10: enables toggled on cycles without a tick
        cur_req = "R10"; sqwe_en = 1;
        for (int i = 0; i < 300; i++) begin
            pie_en = (i % 5) < 2;
            sqwe_en = (i % 7) > 3;
            step((i % 4) == 0);
        end
        // R9: one-clock pulses with ticks on every clock
        cur_req = "R9"; rate_code = 4'd3; pie_en = 1; sqwe_en = 1;
        run(64, 1);
        // R11: wrap of the base count with selector 15
        cur_req = "R11"; rate_code = 4'd15;
        run(33500, 1);
        // R1: reset mid-run then restart
        cur_req = "R1"; rst_n = 0; run(3, 1);
        rst_n = 1; rate_code = 4'd3; run(20, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule